// File: doc/BRIEF.md
# Packed-Data Low-Half Interleave Unit

This block is a pipelined permute stage for a packed-data execution path. Each operation supplies two operands, called the destination and the source, plus an element size and a width mode. The result is built by alternating elements taken from the low half of each operand. The element at position 0 comes from the destination, the one at position 1 from the source, then the next destination element, and so on. The elements in the upper halves of both operands take no part.

Two width modes are offered. In the 128-bit mode the low 64 bits of each operand feed a 128-bit result. In the 64-bit mode only bits 31..0 of each operand feed a 64-bit result, and the upper result half is driven to zero. Filling the source with zeros turns the operation into a zero extension of the destination's low elements to twice their width, which is a common use.

A new operation may enter on every cycle. Its result appears after a fixed two-cycle latency. The quadword size has no 64-bit form. Such a request is flagged on a separate illegal-operation output with the same latency, and it produces no valid result.

Top module: `simd_unpack_lo`

## Requirements
- R1: With `in_esz`=00 (byte) and `in_wide`=1 (128-bit), result byte 2i equals destination byte i and result byte 2i+1 equals source byte i, for i = 0..7.
- R2: With `in_esz`=00 and `in_wide`=0 (64-bit), result byte 2i equals destination byte i and result byte 2i+1 equals source byte i, for i = 0..3.
- R3: With `in_esz`=01 (16-bit word), result word 2i equals destination word i and result word 2i+1 equals source word i, for i = 0..3 in 128-bit mode and i = 0..1 in 64-bit mode.
- R4: With `in_esz`=10 (32-bit doubleword), the 64-bit mode result is {source dw0, destination dw0}, and the 128-bit mode result is destination dw0, source dw0, destination dw1, source dw1 from the LSB upward.
- R5: With `in_esz`=11 (64-bit quadword) and `in_wide`=1, the result is {source bits 63..0, destination bits 63..0}.
- R6: When the source is all zeros, the result equals the destination's consumed low elements, each zero-extended to twice its width.
- R7: In 64-bit mode, result bits 127..64 are zero. Operand bits above bit 31 in 64-bit mode, and above bit 63 in 128-bit mode, have no effect on the result.
- R8: An operation presented with `in_vld` high on a rising edge yields `out_vld` high for exactly one cycle, after the second following rising edge. Operations may be presented on every cycle, and each result then appears on consecutive cycles.
- R9: A request with `in_esz`=11 and `in_wide`=0 raises `out_illegal` at the latency of R8, keeps `out_vld` low and drives `out_res` to zero.
- R10: A synchronous active-high `rst` clears `out_vld` and `out_illegal` and discards every operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation request strobe |
| in_dst | input | DATA_W (128) | Destination operand; supplies the even result elements |
| in_src | input | DATA_W (128) | Source operand; supplies the odd result elements |
| in_esz | input | 2 | Element size: 00 byte, 01 word, 10 doubleword, 11 quadword |
| in_wide | input | 1 | Width mode: 0 selects 64-bit, 1 selects 128-bit |
| out_vld | output | 1 | Result valid strobe |
| out_res | output | DATA_W (128) | Interleaved result |
| out_illegal | output | 1 | Quadword requested in 64-bit mode |

## Verification
The interesting overlap is an illegal quadword request in 64-bit mode placed directly between legal requests, so that its illegal flag and a neighbour's valid result sit in adjacent pipeline stages in the same cycle. The bench issues such a run every cycle and checks that the two strobes never merge and never shift in time. It also checks that the illegal slot still carries a zero result. A second overlap is a reset that arrives while results are in flight. It is raised in the middle of a back-to-back stream, and the reference model expects both queued results to vanish while the next request after reset goes through normally.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'b00,
      ESZ_WORD = 2'b01,
      ESZ_DWRD = 2'b10,
      ESZ_QWRD = 2'b11
   } esz_e;

   localparam int N_SIZES  = 4;
   localparam int BASE_EW  = 8;

   // element width in bits for size index g
   function automatic int elem_bits(input int g);
      return BASE_EW << g;
   endfunction

   // a request is legal unless it asks for quadwords in narrow mode
   function automatic logic size_legal(input logic [1:0] esz, input logic wide);
      return !((esz == ESZ_QWRD) && !wide);
   endfunction

endpackage

// File: rtl/unpk_ilv.sv
module unpk_ilv #(
   parameter int DATA_W = 128,
   parameter int ELEM_W = 8
) (
   input  logic [DATA_W-1:0] d,
   input  logic [DATA_W-1:0] s,
   input  logic              wide,
   output logic [DATA_W-1:0] r
);
   localparam int HALF_W   = DATA_W / 2;
   localparam int N_WIDE   = HALF_W / ELEM_W;
   localparam int N_NARROW = HALF_W / (2 * ELEM_W);

   logic [DATA_W-1:0] r_wide;
   logic [DATA_W-1:0] r_narrow;

   // full-width form: low half of each operand spread over the result
   for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
      assign r_wide[(2*i)*ELEM_W   +: ELEM_W] = d[i*ELEM_W +: ELEM_W];
      assign r_wide[(2*i+1)*ELEM_W +: ELEM_W] = s[i*ELEM_W +: ELEM_W];
   end

   // half-width form: low quarter of each operand, upper half of result zero
   if (N_NARROW > 0) begin : g_nar
      for (genvar i = 0; i < N_NARROW; i++) begin : g_el
         assign r_narrow[(2*i)*ELEM_W   +: ELEM_W] = d[i*ELEM_W +: ELEM_W];
         assign r_narrow[(2*i+1)*ELEM_W +: ELEM_W] = s[i*ELEM_W +: ELEM_W];
      end
   end else begin : g_nar_none
      assign r_narrow[HALF_W-1:0] = '0;
   end
   assign r_narrow[DATA_W-1:HALF_W] = '0;

   assign r = wide ? r_wide : r_narrow;

endmodule

// File: rtl/unpk_pipe.sv
module unpk_pipe #(
   parameter int DATA_W = 128,
   parameter int FLAG_W = 2,
   parameter int DEPTH  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FLAG_W-1:0] i_flg,
   input  logic [DATA_W-1:0] i_dat,
   output logic [FLAG_W-1:0] o_flg,
   output logic [DATA_W-1:0] o_dat
);
   if (DEPTH == 0) begin : g_thru
      assign o_flg = i_flg;
      assign o_dat = i_dat;
   end else begin : g_regs
      logic [FLAG_W-1:0] flg_q [DEPTH];
      logic [DATA_W-1:0] dat_q [DEPTH];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 0; k < DEPTH; k++) flg_q[k] <= '0;
         end else begin
            flg_q[0] <= i_flg;
            for (int k = 1; k < DEPTH; k++) flg_q[k] <= flg_q[k-1];
         end
      end

      always_ff @(posedge clk) begin
         dat_q[0] <= i_dat;
         for (int k = 1; k < DEPTH; k++) dat_q[k] <= dat_q[k-1];
      end

      assign o_flg = flg_q[DEPTH-1];
      assign o_dat = dat_q[DEPTH-1];
   end

endmodule

// File: rtl/simd_unpack_lo.sv
module simd_unpack_lo
   import unpk_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_dst,
   input  logic [DATA_W-1:0] in_src,
   input  logic [1:0]        in_esz,
   input  logic              in_wide,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_res,
   output logic              out_illegal
);
   localparam int TAIL = LAT - 1;

   if (LAT < 2) begin : g_bad_lat
      $error("simd_unpack_lo: LAT must be at least 2");
   end
   if ((DATA_W < 128) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_w
      $error("simd_unpack_lo: DATA_W must be a power of two of at least 128");
   end

   // operand capture stage
   logic              a_vld, a_ill, a_wide;
   logic [1:0]        a_esz;
   logic [DATA_W-1:0] a_dst, a_src;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_vld <= 1'b0;
         a_ill <= 1'b0;
      end else begin
         a_vld <= in_vld &&  size_legal(in_esz, in_wide);
         a_ill <= in_vld && !size_legal(in_esz, in_wide);
      end
   end

   always_ff @(posedge clk) begin
      a_esz  <= in_esz;
      a_wide <= in_wide;
      a_dst  <= in_dst;
      a_src  <= in_src;
   end

   // one interleave network per element size
   logic [DATA_W-1:0] by_size [N_SIZES];

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      unpk_ilv #(
         .DATA_W (DATA_W),
         .ELEM_W (elem_bits(g))
      ) i_ilv (
         .d    (a_dst),
         .s    (a_src),
         .wide (a_wide),
         .r    (by_size[g])
      );
   end

   logic [DATA_W-1:0] a_res;
   assign a_res = a_ill ? '0 : by_size[a_esz];

   // remaining latency
   logic [1:0] t_flg;

   unpk_pipe #(
      .DATA_W (DATA_W),
      .FLAG_W (2),
      .DEPTH  (TAIL)
   ) i_pipe (
      .clk   (clk),
      .rst   (rst),
      .i_flg ({a_ill, a_vld}),
      .i_dat (a_res),
      .o_flg (t_flg),
      .o_dat (out_res)
   );

   assign out_vld     = t_flg[0];
   assign out_illegal = t_flg[1];

endmodule

// File: rtl/unpk_chk.sv
module unpk_chk #(
   parameter int DATA_W = 128,
   parameter int LAT    = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_dst,
   input logic [DATA_W-1:0] in_src,
   input logic [1:0]        in_esz,
   input logic              in_wide,
   input logic              out_vld,
   input logic [DATA_W-1:0] out_res,
   input logic              out_illegal
);
   // short history of requests, depth LAT
   logic [LAT-1:0] h_ok, h_bad, h_nar;
   logic [7:0]     h_b0 [LAT];

   always_ff @(posedge clk) begin
      if (rst) begin
         h_ok  <= '0;
         h_bad <= '0;
      end else begin
         h_ok  <= {h_ok[LAT-2:0],  in_vld && !(in_esz == 2'b11 && !in_wide)};
         h_bad <= {h_bad[LAT-2:0], in_vld &&  (in_esz == 2'b11 && !in_wide)};
      end
   end

   always_ff @(posedge clk) begin
      h_nar   <= {h_nar[LAT-2:0], !in_wide};
      h_b0[0] <= in_dst[7:0];
      for (int k = 1; k < LAT; k++) h_b0[k] <= h_b0[k-1];
   end

   a_r8_vld_latency: assert property (@(posedge clk) disable iff (rst)
      out_vld == h_ok[LAT-1]);

   a_r9_illegal_latency: assert property (@(posedge clk) disable iff (rst)
      out_illegal == h_bad[LAT-1]);

   a_r9_no_vld_with_illegal: assert property (@(posedge clk) disable iff (rst)
      !(out_vld && out_illegal));

   a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (out_res == '0));

   a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (out_vld && h_nar[LAT-1]) |-> (out_res[DATA_W-1:DATA_W/2] == '0));

   a_r1_first_elem: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_res[7:0] == h_b0[LAT-1]));

endmodule

bind simd_unpack_lo unpk_chk #(.DATA_W(DATA_W), .LAT(LAT)) i_chk (.*);

// File: tb/test_simd_unpack_lo.sv
module test_simd_unpack_lo;
   localparam int CLK_PERIOD = 10;
   localparam int W = 128;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [W-1:0] in_dst = '0;
   logic [W-1:0] in_src = '0;
   logic [1:0]   in_esz = 2'b00;
   logic         in_wide = 1'b0;
   logic         out_vld;
   logic [W-1:0] out_res;
   logic         out_illegal;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_unpack_lo #(.DATA_W(W), .LAT(2)) i_simd_unpack_lo (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_src(in_src),
      .in_esz(in_esz), .in_wide(in_wide), .out_vld(out_vld), .out_res(out_res),
      .out_illegal(out_illegal)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // two-slot expectation pipeline: [0] newest, [1] due now
   logic         e_v [2] = '{1'b0, 1'b0};
   logic         e_i [2] = '{1'b0, 1'b0};
   logic [W-1:0] e_r [2] = '{'0, '0};
   string        e_t [2] = '{"R10", "R10"};

   function automatic logic [W-1:0] ref_unpack(input logic [W-1:0] d, input logic [W-1:0] s,
                                               input logic [1:0] z, input logic w);
      logic [W-1:0] r = '0;
      int ew = 8 << z;
      int n  = (w ? 64 : 32) / ew;
      if (!w && z == 2'b11) return '0;
      for (int i = 0; i < n; i++)
         for (int b = 0; b < ew; b++) begin
            r[2*i*ew + b]     = d[i*ew + b];
            r[(2*i+1)*ew + b] = s[i*ew + b];
         end
      return r;
   endfunction

   task automatic compare();
      logic ok;
      ok = (out_vld === e_v[1]) && (out_illegal === e_i[1]) &&
           ((e_v[1] || e_i[1]) ? (out_res === e_r[1]) : 1'b1);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: vld=%b ill=%b res=%h expected vld=%b ill=%b res=%h",
                  e_t[1], out_vld, out_illegal, out_res, e_v[1], e_i[1], e_r[1]);
      end
   endtask

   task automatic step(input logic r, input logic v, input logic [W-1:0] d,
                       input logic [W-1:0] s, input logic [1:0] z, input logic w,
                       input string tag);
      @(negedge clk);
      compare();
      e_v[1] = e_v[0]; e_i[1] = e_i[0]; e_r[1] = e_r[0]; e_t[1] = e_t[0];
      e_t[0] = tag;
      if (r || !v) begin
         e_v[0] = 1'b0; e_i[0] = 1'b0; e_r[0] = '0;
      end else begin
         e_v[0] = !(z == 2'b11 && !w);
         e_i[0] =  (z == 2'b11 && !w);
         e_r[0] = ref_unpack(d, s, z, w);
      end
      if (r) begin
         e_v[1] = 1'b0; e_i[1] = 1'b0;
         e_v[0] = 1'b0; e_i[0] = 1'b0;
      end
      rst = r; in_vld = v; in_dst = d; in_src = s; in_esz = z; in_wide = w;
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, 2'b00, 1'b0, tag);
   endtask

   function automatic logic [W-1:0] rnd();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   localparam logic [W-1:0] D_PAT = 128'hF0E1D2C3B4A59687_7766554433221100;
   localparam logic [W-1:0] S_PAT = 128'h0F1E2D3C4B5A6978_FFEEDDCCBBAA9988;

   initial begin
      // R10: outputs held clear during reset
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, D_PAT, S_PAT, 2'b00, 1'b1, "R10");
      idle(2, "R10");

      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b00, 1'b1, "R1");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b00, 1'b0, "R2");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b01, 1'b1, "R3");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b01, 1'b0, "R3");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b10, 1'b1, "R4");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b10, 1'b0, "R4");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b11, 1'b1, "R5");
      idle(3, "R8");

      // R6: zero source gives zero extension
      for (int z = 0; z < 4; z++) begin
         step(1'b0, 1'b1, D_PAT, '0, z[1:0], 1'b1, "R6");
         if (z < 3) step(1'b0, 1'b1, D_PAT, '0, z[1:0], 1'b0, "R6");
      end
      idle(2, "R8");

      // R7: upper operand bits must not matter; same low bits, different high bits
      step(1'b0, 1'b1, {64'hDEAD_BEEF_0BAD_F00D, 32'h1234_5678, 32'h9ABC_DEF0},
                       {64'hFFFF_FFFF_FFFF_FFFF, 32'hCAFE_BABE, 32'h0011_2233}, 2'b00, 1'b0, "R7");
      step(1'b0, 1'b1, {64'h0, 32'h0, 32'h9ABC_DEF0},
                       {64'h0, 32'h0, 32'h0011_2233}, 2'b00, 1'b0, "R7");
      step(1'b0, 1'b1, {64'hAAAA_5555_AAAA_5555, 64'h0123_4567_89AB_CDEF},
                       {64'h5555_AAAA_5555_AAAA, 64'hFEDC_BA98_7654_3210}, 2'b01, 1'b1, "R7");
      idle(2, "R7");

      // R9: illegal request sandwiched between legal ones
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b10, 1'b1, "R9");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b11, 1'b0, "R9");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b11, 1'b1, "R9");
      step(1'b0, 1'b1, rnd(),  rnd(),  2'b11, 1'b0, "R9");
      step(1'b0, 1'b1, rnd(),  rnd(),  2'b11, 1'b0, "R9");
      idle(2, "R9");

      // R8: back-to-back stream over all sizes and modes
      for (int k = 0; k < 200; k++)
         step(1'b0, 1'b1, rnd(), rnd(), 2'($urandom_range(3)), 1'($urandom_range(1)), "R8");
      idle(2, "R8");

      // R10: reset in the middle of a stream discards in-flight work
      step(1'b0, 1'b1, rnd(), rnd(), 2'b00, 1'b1, "R10");
      step(1'b0, 1'b1, rnd(), rnd(), 2'b11, 1'b0, "R10");
      step(1'b1, 1'b1, rnd(), rnd(), 2'b01, 1'b1, "R10");
      step(1'b0, 1'b1, D_PAT, S_PAT, 2'b00, 1'b1, "R10");
      idle(3, "R10");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule